// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames into memory under the control of a ring of receive descriptors. Software builds the descriptors in a small local memory, which the block reaches through its host port. The engine fetches the descriptor at its current position. If the engine owns that descriptor, it reads the descriptor's two buffer sizes and two buffer addresses. It then accepts a byte stream and fills buffer one first and buffer two after it. When the last byte arrives, the engine writes a completion word back into the descriptor. That word returns the descriptor to the host and carries the stored length and the frame status.

If a fetched descriptor still belongs to the host, the engine suspends, raises `stalled` and refuses input. It stays that way until software writes a poll demand, after which it fetches the same descriptor again. A descriptor whose wrap flag is set sends the engine back to the ring base. Any other descriptor is followed by the one eight words further on. The ring base can only be loaded while the engine is stopped, and every start begins at the base.

Each descriptor is eight 32-bit words. Word 0 holds ownership, length and status. Word 1 holds the two sizes and the wrap flag. Words 2 and 3 hold the byte addresses of buffer one and buffer two. The remaining words are ignored.

The state machine has eight states:
- IDLE: stopped.
- FETCH: read word 0 and test ownership.
- SUSPEND: stalled on a host-owned descriptor.
- SIZES: read word 1.
- ADDR1: read word 2.
- ADDR2: read word 3.
- RECV: accept bytes.
- WBACK: write word 0 and advance.

The transitions are:
- IDLE to FETCH when `run` is high.
- FETCH to SIZES when the engine owns the descriptor, to SUSPEND when the host owns it, and to IDLE when `run` is low.
- SUSPEND to FETCH on `poll`, and to IDLE when `run` is low.
- SIZES to ADDR1 to ADDR2 to RECV, one cycle each.
- RECV to WBACK when the last byte is accepted.
- WBACK to FETCH while running, or to IDLE when `run` is low.

Top module: `rxr_engine`

## Requirements
- R1: After reset, `stalled`, `s_ready` and `frame_done` are low, and the engine is stopped.
- R2: Bit 31 of word 0 gives ownership: 1 means the engine owns the descriptor, 0 means the host owns it. On a host-owned descriptor the engine holds `stalled` high and `s_ready` low, and leaves the descriptor unchanged.
- R3: While stopped in SUSPEND with `run` high, `stalled` stays high until `poll` is pulsed. A poll makes the engine re-read the same descriptor's ownership bit.
- R4: Stream byte k goes to byte address buf1+k when k is below the buffer-one size (word 1 bits 12:0). Otherwise it goes to buf2+(k−size1), where the buffer-two size is word 1 bits 28:16. Byte lane addr[1:0] selects bits 8·lane+7 down to 8·lane of the word.
- R5: The completion write to word 0 does three things:
  - It clears bit 31.
  - It puts the stored byte count in bits 29:16. The count includes every delivered byte, so for typed frames it includes the 4 FCS bytes.
  - It sets bit 9 (first segment) and bit 8 (last segment).
- R6: The `s_flags` value sampled with the last byte maps into word 0 as follows: [0] CRC error to bit 1, [1] receive error to bit 3, [2] watchdog to bit 4, [3] frame type to bit 5, [4] giant frame to bit 7. All other bits of word 0 stay 0.
- R7: Bit 15 of word 0 is the OR of the CRC error, receive error, watchdog, giant frame and length error bits. The frame-type bit does not feed it.
- R8: Bytes beyond size1+size2 are dropped without any memory write. The reported length is then equal to the capacity, and bit 12 (length error) is set.
- R9: After completing a descriptor whose word 1 bit 15 is set, the next fetch is at the ring base. After any other descriptor, the next fetch is at the current address plus 8 words.
- R10: `base_load` takes effect only while the engine is stopped. Starting from stopped always begins at the ring base.
- R11: `frame_done` is a one-cycle pulse, given once per completed frame. `s_ready` is high only while a frame is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine enable; low stops it at a frame boundary |
| base_load | input | 1 | Load the ring base (honoured only while stopped) |
| base_value | input | AW | Ring base word address |
| poll | input | 1 | Poll demand: re-fetch after a stall |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_flags | input | 5 | Frame status flags, sampled with the last byte |
| s_ready | output | 1 | Engine accepts a byte |
| stalled | output | 1 | Suspended on a host-owned descriptor |
| frame_done | output | 1 | One-cycle pulse at descriptor completion |
| host_we | input | 1 | Host word write to local memory |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |

## Verification
A wrong ring position shows up as a completion word written into the wrong descriptor. The host port exposes this immediately after the cycle that follows the last byte. A wrong ownership or suspend state shows as `stalled` or `s_ready` taking the wrong value within a few cycles of the fetch. A wrong byte counter or buffer split shows as misplaced bytes, a wrong length field, or a write beyond the capacity guard, all read back as soon as the frame completes.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int DESC_WORDS = 8;
    localparam int SZ_W       = 13;
    localparam int LEN_W      = 14;
    localparam int FLAG_W     = 5;

    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 15;
    localparam int SZ2_LSB    = 16;
    localparam int LEN_LSB    = 16;
    localparam int FIRST_BIT  = 9;
    localparam int LASTS_BIT  = 8;
    localparam int CRC_BIT    = 1;
    localparam int RXE_BIT    = 3;
    localparam int WDG_BIT    = 4;
    localparam int TYPE_BIT   = 5;
    localparam int GIANT_BIT  = 7;
    localparam int LENE_BIT   = 12;
    localparam int SUMM_BIT   = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SUSP,
        ST_SIZES,
        ST_ADDR1,
        ST_ADDR2,
        ST_RECV,
        ST_WBACK
    } rxr_state_e;
endpackage

// File: rtl/rxr_mem.sv
`timescale 1ns/1ps
module rxr_mem #(
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          eng_we,
    input  logic [3:0]    eng_be,
    input  logic [AW-1:0] eng_addr,
    input  logic [31:0]   eng_wdata,
    output logic [31:0]   eng_rdata
);
    logic [31:0] store [WORDS];

    // Engine byte writes land after host writes, so the engine wins a same-word collision.
    always_ff @(posedge clk) begin
        if (host_we) begin
            store[host_addr] <= host_wdata;
        end
        for (int b = 0; b < 4; b++) begin
            if (eng_we && eng_be[b]) begin
                store[eng_addr][8*b +: 8] <= eng_wdata[8*b +: 8];
            end
        end
    end

    assign host_rdata = store[host_addr];
    assign eng_rdata  = store[eng_addr];
endmodule

// File: rtl/rxr_place.sv
`timescale 1ns/1ps
module rxr_place
    import rxr_pkg::*;
#(
    parameter int BA_W = 10
) (
    input  logic [LEN_W-1:0] cnt,
    input  logic [SZ_W-1:0]  size1,
    input  logic [SZ_W-1:0]  size2,
    input  logic [BA_W-1:0]  addr1,
    input  logic [BA_W-1:0]  addr2,
    output logic [BA_W-1:0]  byte_addr,
    output logic [LEN_W-1:0] cap,
    output logic             full
);
    logic [LEN_W-1:0] s1_ext;
    logic [LEN_W-1:0] over;

    assign s1_ext = {1'b0, size1};
    assign cap    = s1_ext + {1'b0, size2};
    assign full   = (cnt >= cap);
    assign over   = cnt - s1_ext;

    always_comb begin
        if (cnt < s1_ext) begin
            byte_addr = addr1 + BA_W'(cnt);
        end else begin
            byte_addr = addr2 + BA_W'(over);
        end
    end
endmodule

// File: rtl/rxr_status.sv
`timescale 1ns/1ps
module rxr_status
    import rxr_pkg::*;
(
    input  logic [LEN_W-1:0]  len,
    input  logic [FLAG_W-1:0] flags,
    input  logic              trunc,
    output logic [31:0]       word
);
    always_comb begin
        word                          = '0;
        word[LEN_LSB +: LEN_W]        = len;
        word[FIRST_BIT]               = 1'b1;
        word[LASTS_BIT]               = 1'b1;
        word[CRC_BIT]                 = flags[0];
        word[RXE_BIT]                 = flags[1];
        word[WDG_BIT]                 = flags[2];
        word[TYPE_BIT]                = flags[3];
        word[GIANT_BIT]               = flags[4];
        word[LENE_BIT]                = trunc;
        word[SUMM_BIT]                = flags[0] | flags[1] | flags[2] | flags[4] | trunc;
    end
endmodule

// File: rtl/rxr_engine.sv
`timescale 1ns/1ps
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int AW       = $clog2(MEM_WORDS),
    localparam int BA_W     = AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              base_load,
    input  logic [AW-1:0]     base_value,
    input  logic              poll,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic [FLAG_W-1:0] s_flags,
    output logic              s_ready,
    output logic              stalled,
    output logic              frame_done,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata
);
    rxr_state_e state_q, state_d;

    logic [AW-1:0]     base_q, cur_q;
    logic [SZ_W-1:0]   size1_q, size2_q;
    logic              wrap_q;
    logic [BA_W-1:0]   addr1_q, addr2_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              trunc_q;
    logic [FLAG_W-1:0] flags_q;

    logic              eng_we;
    logic [3:0]        eng_be;
    logic [AW-1:0]     eng_addr;
    logic [31:0]       eng_wdata, eng_rdata;
    logic [BA_W-1:0]   byte_addr;
    logic [LEN_W-1:0]  cap;
    logic              full;
    logic [31:0]       wb_word;
    logic              accept;
    logic              busy;
    logic              unused_rd;

    assign accept    = (state_q == ST_RECV) && s_valid;
    assign busy      = (state_q != ST_IDLE);
    assign unused_rd = ^eng_rdata;

    rxr_mem #(.WORDS(MEM_WORDS)) u_mem (
        .clk        (clk),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_be     (eng_be),
        .eng_addr   (eng_addr),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (eng_rdata)
    );

    rxr_place #(.BA_W(BA_W)) u_place (
        .cnt       (cnt_q),
        .size1     (size1_q),
        .size2     (size2_q),
        .addr1     (addr1_q),
        .addr2     (addr2_q),
        .byte_addr (byte_addr),
        .cap       (cap),
        .full      (full)
    );

    rxr_status u_status (
        .len   (cnt_q),
        .flags (flags_q),
        .trunc (trunc_q),
        .word  (wb_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_FETCH;
            ST_FETCH: begin
                if (!run)                      state_d = ST_IDLE;
                else if (eng_rdata[OWN_BIT])   state_d = ST_SIZES;
                else                           state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (!run)      state_d = ST_IDLE;
                else if (poll) state_d = ST_FETCH;
            end
            ST_SIZES: state_d = ST_ADDR1;
            ST_ADDR1: state_d = ST_ADDR2;
            ST_ADDR2: state_d = ST_RECV;
            ST_RECV:  if (accept && s_last) state_d = ST_WBACK;
            ST_WBACK: state_d = run ? ST_FETCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and memory port
    always_comb begin
        s_ready    = 1'b0;
        stalled    = 1'b0;
        frame_done = 1'b0;
        eng_we     = 1'b0;
        eng_be     = 4'h0;
        eng_addr   = cur_q;
        eng_wdata  = {4{s_data}};
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: eng_addr = cur_q;
            ST_SUSP:  stalled = 1'b1;
            ST_SIZES: eng_addr = cur_q + AW'(1);
            ST_ADDR1: eng_addr = cur_q + AW'(2);
            ST_ADDR2: eng_addr = cur_q + AW'(3);
            ST_RECV: begin
                s_ready  = 1'b1;
                eng_addr = byte_addr[BA_W-1:2];
                eng_be   = 4'b0001 << byte_addr[1:0];
                eng_we   = accept && !full;
            end
            ST_WBACK: begin
                frame_done = 1'b1;
                eng_we     = 1'b1;
                eng_be     = 4'hF;
                eng_addr   = cur_q;
                eng_wdata  = wb_word;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            cur_q   <= '0;
            size1_q <= '0;
            size2_q <= '0;
            wrap_q  <= 1'b0;
            addr1_q <= '0;
            addr2_q <= '0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (base_load) base_q <= base_value;
                    if (run)       cur_q  <= base_q;
                end
                ST_SIZES: begin
                    size1_q <= eng_rdata[SZ_W-1:0];
                    size2_q <= eng_rdata[SZ2_LSB +: SZ_W];
                    wrap_q  <= eng_rdata[WRAP_BIT];
                end
                ST_ADDR1: addr1_q <= eng_rdata[BA_W-1:0];
                ST_ADDR2: begin
                    addr2_q <= eng_rdata[BA_W-1:0];
                    cnt_q   <= '0;
                    trunc_q <= 1'b0;
                end
                ST_RECV: begin
                    if (accept) begin
                        if (full) trunc_q <= 1'b1;
                        else      cnt_q   <= cnt_q + LEN_W'(1);
                        if (s_last) flags_q <= s_flags;
                    end
                end
                ST_WBACK: cur_q <= wrap_q ? base_q : cur_q + AW'(DESC_WORDS);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxr_engine_chk.sv
`timescale 1ns/1ps
module rxr_engine_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          poll,
    input logic          s_ready,
    input logic          stalled,
    input logic          frame_done,
    input logic          busy,
    input logic [AW-1:0] base_q,
    input logic          eng_we,
    input logic [3:0]    eng_be,
    input logic [31:0]   eng_wdata,
    input logic [13:0]   cap
);
    // R2
    ready_vs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !s_ready);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && run && !poll) |=> stalled);

    // R10
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !s_ready);

    // R5
    wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (eng_we && eng_be == 4'hF && !eng_wdata[31]));

    // R8
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (eng_wdata[29:16] <= cap));
endmodule

bind rxr_engine rxr_engine_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .poll       (poll),
    .s_ready    (s_ready),
    .stalled    (stalled),
    .frame_done (frame_done),
    .busy       (busy),
    .base_q     (base_q),
    .eng_we     (eng_we),
    .eng_be     (eng_be),
    .eng_wdata  (eng_wdata),
    .cap        (cap)
);

// File: tb/rxr_engine_test.sv
`timescale 1ns/1ps
module rxr_engine_test;
    localparam int MW = 256;
    localparam int AW = 8;
    localparam int RING = 32;
    localparam int ALT  = 96;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, run, base_load, poll, s_valid, s_last, host_we;
    logic [AW-1:0] base_value, host_addr;
    logic [7:0] s_data;
    logic [4:0] s_flags;
    logic [31:0] host_wdata, host_rdata;
    logic s_ready, stalled, frame_done;

    int total = 0;
    int bad = 0;
    int done_seen = 0;

    rxr_engine #(.MEM_WORDS(MW)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .base_load(base_load),
        .base_value(base_value), .poll(poll), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_flags(s_flags),
        .s_ready(s_ready), .stalled(stalled), .frame_done(frame_done),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    always @(negedge clk) if (frame_done === 1'b1) done_seen++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input int a, output logic [31:0] d);
        host_addr = AW'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic rb(input int ba, output logic [7:0] b);
        logic [31:0] w;
        hr(ba / 4, w);
        b = w[8*(ba%4) +: 8];
    endtask

    function automatic int sz1_of(input int idx); return idx + 2; endfunction
    function automatic int sz2_of(input int idx); return 8 - idx; endfunction
    function automatic int b1_of(input int idx);  return 512 + idx*32; endfunction
    function automatic int b2_of(input int idx);  return 768 + idx*32; endfunction

    task automatic arm(input int wa, input int idx, input bit wrap);
        for (int w = 0; w < 8; w++) begin
            hw(b1_of(idx)/4 + w, 32'h0);
            hw(b2_of(idx)/4 + w, 32'h0);
        end
        hw(wa + 1, 32'(sz1_of(idx)) | (32'(sz2_of(idx)) << 16) | (32'(wrap) << 15));
        hw(wa + 2, 32'(b1_of(idx)));
        hw(wa + 3, 32'(b2_of(idx)));
        hw(wa, 32'h8000_0000);
    endtask

    function automatic logic [7:0] dbyte(input int seed, input int k);
        return 8'((seed*16 + k + 1) & 255);
    endfunction

    task automatic send(input int len, input logic [4:0] fl, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = dbyte(seed, k);
            s_last = (k == len-1); s_flags = fl;
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        @(negedge clk);
    endtask

    // Expected completion word from R5..R8
    function automatic logic [31:0] exp_w0(input int len, input logic [4:0] fl, input int cap);
        int st; bit tr; logic [31:0] w;
        st = (len > cap) ? cap : len;
        tr = (len > cap);
        w = (32'(st) << 16) | 32'h300;
        w[1] = fl[0]; w[3] = fl[1]; w[4] = fl[2]; w[5] = fl[3]; w[7] = fl[4];
        w[12] = tr;
        w[15] = fl[0] | fl[1] | fl[2] | fl[4] | tr;
        return w;
    endfunction

    task automatic check_frame(input string tag, input int wa, input int idx, input int len,
                               input logic [4:0] fl, input int seed);
        logic [31:0] w, e;
        logic [7:0] b;
        int cap, st, ba;
        cap = sz1_of(idx) + sz2_of(idx);
        st = (len > cap) ? cap : len;
        e = exp_w0(len, fl, cap);
        hr(wa, w);
        chk(tag, "completion word", w, e);
        chk("R6", "flag bits", w & 32'h0000_00BA, e & 32'h0000_00BA);
        chk("R7", "summary bit", {31'b0, w[15]}, {31'b0, e[15]});
        for (int k = 0; k < st; k++) begin
            ba = (k < sz1_of(idx)) ? b1_of(idx) + k : b2_of(idx) + k - sz1_of(idx);
            rb(ba, b);
            chk("R4", "buffer byte", {24'b0, b}, {24'b0, dbyte(seed, k)});
        end
        rb(b2_of(idx) + sz2_of(idx), b);
        chk("R8", "guard byte past capacity", {24'b0, b}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int d, len;
        logic [4:0] fl;
        rst_n = 1'b0; run = 1'b0; base_load = 1'b0; base_value = '0; poll = 1'b0;
        s_valid = 1'b0; s_data = '0; s_last = 1'b0; s_flags = '0;
        host_we = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", "stalled", {31'b0, stalled}, 32'h0);
        chk("R1", "s_ready", {31'b0, s_ready}, 32'h0);
        chk("R1", "frame_done", {31'b0, frame_done}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 4; i++) arm(RING + 8*i, i, i == 3);
        @(negedge clk); base_value = AW'(RING); base_load = 1'b1;
        @(negedge clk); base_load = 1'b0; run = 1'b1;

        // Sweep lengths 1..12 over capacity 10 with varied flags; ring wraps every 4 frames
        for (int f = 0; f < 16; f++) begin
            d = f % 4;
            len = (f % 12) + 1;
            fl = 5'((f * 7) % 32);
            send(len, fl, f);
            check_frame((len > 10) ? "R8" : ((f >= 4 && d == 0) ? "R9" : "R5"),
                        RING + 8*d, d, len, fl, f);
            if (f < 12) arm(RING + 8*d, d, d == 3);
        end

        // Descriptor 0 now host-owned after the wrap
        repeat (4) @(negedge clk);
        chk("R2", "stalled on host descriptor", {31'b0, stalled}, 32'h1);
        s_valid = 1'b1; s_data = 8'hEE; s_last = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", "s_ready while stalled", {31'b0, s_ready}, 32'h0);
        s_valid = 1'b0; s_last = 1'b0;
        hr(RING, w);
        chk("R2", "host descriptor untouched", w, exp_w0(1, 5'((12*7)%32), 10));
        arm(RING, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R3", "still stalled without poll", {31'b0, stalled}, 32'h1);
        poll = 1'b1; @(negedge clk); poll = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3", "stall released by poll", {31'b0, stalled}, 32'h0);
        send(7, 5'd9, 16);
        check_frame("R3", RING, 0, 7, 5'd9, 16);

        // Descriptor 1 is host-owned: stalled, then try a base load while running
        repeat (4) @(negedge clk);
        chk("R9", "advance to next descriptor stalls", {31'b0, stalled}, 32'h1);
        base_value = AW'(ALT); base_load = 1'b1; @(negedge clk); base_load = 1'b0;
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "stopped drops stall", {31'b0, stalled}, 32'h0);
        arm(RING, 0, 1'b0);
        arm(ALT, 4, 1'b1);
        run = 1'b1;
        send(5, 5'd2, 17);
        check_frame("R10", RING, 0, 5, 5'd2, 17);
        hr(ALT, w);
        chk("R10", "ignored base untouched", w, 32'h8000_0000);

        // Stop, load new base while stopped, start
        repeat (4) @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        base_value = AW'(ALT); base_load = 1'b1; @(negedge clk); base_load = 1'b0;
        run = 1'b1;
        send(10, 5'd16, 18);
        check_frame("R10", ALT, 4, 10, 5'd16, 18);
        repeat (4) @(negedge clk);
        chk("R9", "wrap returns to base (host-owned)", {31'b0, stalled}, 32'h1);

        chk("R11", "completion pulses", 32'(done_seen), 32'd19);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule